// File: doc/BRIEF.md
# Privilege-Mode Banked Register File

This block holds the general registers and the status words of a processor core that runs in several privilege modes. Sixteen 32-bit architectural registers are addressed by a 4-bit index. The mode field in the low five bits of the current status word decides which physical copy each index reaches. The fast-interrupt mode has its own copies of indices 8 to 14. Each of the other four exception modes has its own copies of indices 13 and 14. Index 15, the program counter, is never duplicated. The core reads two registers and writes one register per cycle. It reads and writes the current status word and the saved status word that belongs to the current mode.

The mode field works as the state of the block. Its named states are user (10000), fast interrupt (10001), interrupt (10010), supervisor (10011), abort (10111), undefined (11011) and system (11111). Any other code behaves like user for register selection. The only transition is a write to the current status word, and it can move the block from any state to any other state. An exception side port lets a controller load the link register (index 14) and the saved status word of a chosen exception mode while the core is still in another mode. The controller then changes the mode through the normal status write.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register and every saved status word reads zero, and the current status word reads 0x000000D3 (supervisor mode, both interrupt-disable bits 7 and 6 set).
- R2: Indices 0 to 7 and index 15 reach the same physical register in every mode.
- R3: In mode 10001, indices 8 to 14 reach seven private registers. Indices 8 to 14 of every other mode are not affected by them.
- R4: In modes 10010, 10011, 10111 and 11011, indices 13 and 14 reach a private pair for each mode, while indices 8 to 12 are shared with user mode.
- R5: Modes 10000 and 11111 reach the same sixteen registers. They have no saved status word: reads return zero and writes are ignored.
- R6: Each of the five exception modes has its own saved status word, and the status read and write ports reach the copy of the current mode.
- R7: The status words keep bits 31:28 and 7:0 as written. Bits 27:8 always read zero.
- R8: A mode code outside the seven listed codes selects registers like user mode and has no saved status word.
- R9: All writes take effect at the clock edge. A read of an index that is written in the same cycle returns the old value.
- R10: When the side port is enabled with an exception mode code, it writes that mode's index-14 register and its saved status word, whatever the current mode is. It overrides a core write to the same register in the same cycle. A side-port write with a non-exception mode code changes nothing.
- R11: A register write in the same cycle as a status-word write is mapped with the mode in effect before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write architectural index |
| wr_data | input | 32 | Register write data |
| cpsr_we | input | 1 | Current status write enable |
| cpsr_wdata | input | 32 | Current status write data |
| cpsr_q | output | 32 | Current status word |
| spsr_we | input | 1 | Saved status write enable (current mode's copy) |
| spsr_wdata | input | 32 | Saved status write data |
| spsr_q | output | 32 | Saved status word of the current mode |
| exc_we | input | 1 | Exception side-port write enable |
| exc_mode | input | 5 | Target mode of the side-port write |
| exc_lr | input | 32 | Value for the target mode's index-14 register |
| exc_spsr | input | 32 | Value for the target mode's saved status word |

## Verification
The hardest case to reach from the ports is a core write and a side-port write that land on the same physical register in one cycle. It is almost as hard to reach a register write that happens in the same cycle as a mode change. In both cases the result only shows after a later mode switch that makes the hidden copy visible. Directed sequences set up these collisions and then switch through the affected modes to read every copy back. A seeded random phase mixes status writes, which include undefined mode codes and junk in the ignored bits, with register, saved-status and side-port writes. It compares both read ports against a bench model on every cycle.

// File: rtl/bank_pkg.sv
package bank_pkg;
    localparam int XLEN    = 32;
    localparam int AIDX_W  = 4;
    localparam int MODE_W  = 5;
    localparam int N_ARCH  = 1 << AIDX_W;
    localparam int FIQ_LO  = 8;
    localparam int FIQ_HI  = 14;
    localparam int N_FIQ   = FIQ_HI - FIQ_LO + 1;
    localparam int N_SMALL = 4;
    localparam int N_PHYS  = N_ARCH + N_FIQ + 2 * N_SMALL;
    localparam int PHYS_W  = $clog2(N_PHYS);
    localparam int FIQ_BASE   = N_ARCH;
    localparam int SMALL_BASE = N_ARCH + N_FIQ;
    localparam int LINK_IDX   = 14;
    localparam int N_SAVED    = N_SMALL + 1;

    localparam logic [XLEN-1:0] STATUS_KEEP  = 32'hF000_00FF;
    localparam logic [XLEN-1:0] STATUS_RESET = 32'h0000_00D3;

    typedef enum logic [MODE_W-1:0] {
        M_USR = 5'b10000,
        M_FIQ = 5'b10001,
        M_IRQ = 5'b10010,
        M_SVC = 5'b10011,
        M_ABT = 5'b10111,
        M_UND = 5'b11011,
        M_SYS = 5'b11111
    } mode_e;

    typedef enum logic [2:0] {
        SB_NONE = 3'd0,
        SB_FIQ  = 3'd1,
        SB_IRQ  = 3'd2,
        SB_SVC  = 3'd3,
        SB_ABT  = 3'd4,
        SB_UND  = 3'd5
    } bank_e;

    function automatic bank_e bank_of(logic [MODE_W-1:0] m);
        bank_e b;
        case (m)
            M_FIQ:   b = SB_FIQ;
            M_IRQ:   b = SB_IRQ;
            M_SVC:   b = SB_SVC;
            M_ABT:   b = SB_ABT;
            M_UND:   b = SB_UND;
            default: b = SB_NONE;
        endcase
        return b;
    endfunction

    function automatic logic [PHYS_W-1:0] phys_of(bank_e b, logic [AIDX_W-1:0] idx);
        logic [PHYS_W-1:0] p;
        p = PHYS_W'(idx);
        unique case (b)
            SB_FIQ: begin
                if (int'(idx) >= FIQ_LO && int'(idx) <= FIQ_HI)
                    p = PHYS_W'(FIQ_BASE + int'(idx) - FIQ_LO);
            end
            SB_IRQ, SB_SVC, SB_ABT, SB_UND: begin
                if (int'(idx) == 13 || int'(idx) == 14)
                    p = PHYS_W'(SMALL_BASE + 2 * (int'(b) - int'(SB_IRQ)) + int'(idx) - 13);
            end
            default: ;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/bank_map.sv
module bank_map
    import bank_pkg::*;
(
    input  bank_e               bank,
    input  logic [AIDX_W-1:0]   idx,
    output logic [PHYS_W-1:0]   phys
);
    always_comb begin
        phys = phys_of(bank, idx);
    end

    always_comb begin
        if (int'(idx) < FIQ_LO || int'(idx) == N_ARCH - 1)
            assert_low_and_pc_shared_R2: assert (phys == PHYS_W'(idx));
    end
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
    parameter int DW = bank_pkg::XLEN,
    parameter int NP = bank_pkg::N_PHYS,
    localparam int PW = $clog2(NP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] rd_a_phys,
    input  logic [PW-1:0] rd_b_phys,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_phys,
    input  logic [DW-1:0] wr_data,
    input  logic          side_en,
    input  logic [PW-1:0] side_phys,
    input  logic [DW-1:0] side_data
);
    logic [DW-1:0] mem [NP];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) mem[i] <= '0;
        end else begin
            if (wr_en)   mem[wr_phys]   <= wr_data;
            if (side_en) mem[side_phys] <= side_data;
        end
    end

    assign rd_a = mem[rd_a_phys];
    assign rd_b = mem[rd_b_phys];

    assert_side_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        side_en |=> mem[$past(side_phys)] == $past(side_data));

    assert_core_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(side_en && side_phys == wr_phys)) |=> mem[$past(wr_phys)] == $past(wr_data));
endmodule

// File: rtl/status_unit.sv
module status_unit
    import bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpsr_we,
    input  logic [XLEN-1:0]   cpsr_wd,
    input  logic              spsr_we,
    input  logic [XLEN-1:0]   spsr_wd,
    input  logic              side_en,
    input  bank_e             side_bank,
    input  logic [XLEN-1:0]   side_wd,
    output logic [XLEN-1:0]   cpsr_q,
    output logic [XLEN-1:0]   spsr_q,
    output bank_e             cur_bank
);
    logic [XLEN-1:0] cpsr_r;
    logic [XLEN-1:0] saved_r [1:N_SAVED];

    assign cur_bank = bank_of(cpsr_r[MODE_W-1:0]);

    always_ff @(posedge clk) begin
        if (!rst_n) cpsr_r <= STATUS_RESET;
        else if (cpsr_we) cpsr_r <= cpsr_wd & STATUS_KEEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 1; b <= N_SAVED; b++) saved_r[b] <= '0;
        end else begin
            for (int b = 1; b <= N_SAVED; b++) begin
                if (side_en && int'(side_bank) == b)
                    saved_r[b] <= side_wd & STATUS_KEEP;
                else if (spsr_we && int'(cur_bank) == b)
                    saved_r[b] <= spsr_wd & STATUS_KEEP;
            end
        end
    end

    always_comb begin
        spsr_q = '0;
        for (int b = 1; b <= N_SAVED; b++)
            if (int'(cur_bank) == b) spsr_q = saved_r[b];
    end

    assign cpsr_q = cpsr_r;

    assert_reset_status_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> cpsr_q == STATUS_RESET);

    assert_status_ignored_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpsr_q[27:8] == '0 && spsr_q[27:8] == '0);

    assert_status_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cpsr_we |=> $stable(cpsr_q));

    for (genvar gb = 1; gb <= N_SAVED; gb++) begin : g_saved_chk
        assert_saved_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!(side_en && int'(side_bank) == gb) && !(spsr_we && int'(cur_bank) == gb))
            |=> $stable(saved_r[gb]));
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_idx,
    output logic [31:0]       rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [31:0]       rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [31:0]       wr_data,
    input  logic              cpsr_we,
    input  logic [31:0]       cpsr_wdata,
    output logic [31:0]       cpsr_q,
    input  logic              spsr_we,
    input  logic [31:0]       spsr_wdata,
    output logic [31:0]       spsr_q,
    input  logic              exc_we,
    input  logic [4:0]        exc_mode,
    input  logic [31:0]       exc_lr,
    input  logic [31:0]       exc_spsr
);
    bank_e             cur_bank;
    bank_e             side_bank;
    logic              side_en;
    logic [PHYS_W-1:0] side_phys;
    logic [PHYS_W-1:0] rd_phys [2];
    logic [PHYS_W-1:0] wr_phys;
    logic [AIDX_W-1:0] rd_idx  [2];

    assign side_bank = bank_of(exc_mode);
    assign side_en   = exc_we && (side_bank != SB_NONE);
    assign side_phys = phys_of(side_bank, AIDX_W'(LINK_IDX));
    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;

    for (genvar gp = 0; gp < 2; gp++) begin : g_rd_map
        bank_map u_map (
            .bank (cur_bank),
            .idx  (rd_idx[gp]),
            .phys (rd_phys[gp])
        );
    end

    bank_map u_wr_map (
        .bank (cur_bank),
        .idx  (wr_idx),
        .phys (wr_phys)
    );

    gpr_store #(.DW(XLEN), .NP(N_PHYS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_phys (rd_phys[0]),
        .rd_b_phys (rd_phys[1]),
        .rd_a      (rd_a_data),
        .rd_b      (rd_b_data),
        .wr_en     (wr_en),
        .wr_phys   (wr_phys),
        .wr_data   (wr_data),
        .side_en   (side_en),
        .side_phys (side_phys),
        .side_data (exc_lr)
    );

    status_unit u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpsr_we   (cpsr_we),
        .cpsr_wd   (cpsr_wdata),
        .spsr_we   (spsr_we),
        .spsr_wd   (spsr_wdata),
        .side_en   (side_en),
        .side_bank (side_bank),
        .side_wd   (exc_spsr),
        .cpsr_q    (cpsr_q),
        .spsr_q    (spsr_q),
        .cur_bank  (cur_bank)
    );

    assert_same_index_same_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == rd_b_idx) |-> rd_a_data == rd_b_data);

    assert_no_saved_in_user_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_bank == SB_NONE) |-> spsr_q == '0);
endmodule

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, cpsr_q, spsr_q;
    logic        wr_en = 0, cpsr_we = 0, spsr_we = 0, exc_we = 0;
    logic [31:0] wr_data = '0, cpsr_wdata = '0, spsr_wdata = '0, exc_lr = '0, exc_spsr = '0;
    logic [4:0]  exc_mode = '0;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    banked_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata), .cpsr_q(cpsr_q),
        .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_q(spsr_q),
        .exc_we(exc_we), .exc_mode(exc_mode), .exc_lr(exc_lr), .exc_spsr(exc_spsr)
    );

    localparam logic [31:0] KEEP = 32'hF000_00FF;

    // bench model: 0..15 common, 16..22 fast-interrupt r8..r14, then pairs
    logic [31:0] m_reg [31];
    logic [31:0] m_cpsr;
    logic [31:0] m_sav [6];

    function automatic int t_bank(logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic int t_map(logic [4:0] m, logic [3:0] i);
        int b = t_bank(m);
        if (b == 1 && i >= 8 && i <= 14) return 16 + int'(i) - 8;
        if (b >= 2 && (i == 13 || i == 14)) return 23 + 2 * (b - 2) + int'(i) - 13;
        return int'(i);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clr();
        wr_en = 0; cpsr_we = 0; spsr_we = 0; exc_we = 0;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk); clr();
    endtask

    task automatic rd(logic [3:0] i, string tag, logic [31:0] exp);
        rd_a_idx = i; rd_b_idx = i; #1;
        chk(tag, rd_a_data, exp);
    endtask

    task automatic setmode(logic [31:0] v);
        cpsr_we = 1; cpsr_wdata = v; tick();
    endtask

    task automatic wreg(logic [3:0] i, logic [31:0] d);
        wr_en = 1; wr_idx = i; wr_data = d; tick();
    endtask

    task automatic do_reset();
        clr(); rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        for (int i = 0; i < 31; i++) m_reg[i] = '0;
        for (int i = 0; i < 6; i++) m_sav[i] = '0;
        m_cpsr = 32'h0000_00D3;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R1: watchdog expired, actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] codes [8] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h15};
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        for (int i = 0; i < 16; i++) rd(4'(i), "R1 reg", 32'h0);
        chk("R1 cpsr", cpsr_q, 32'h0000_00D3);
        chk("R1 spsr", spsr_q, 32'h0);

        // supervisor writes
        wreg(13, 32'hA000_0013); wreg(14, 32'hA000_0014);
        wreg(0, 32'h0000_0100);  wreg(8, 32'h0000_0808);
        setmode(32'h10);
        rd(13, "R4 user r13", 32'h0);
        rd(14, "R4 user r14", 32'h0);
        rd(8,  "R4 r8 shared", 32'h0808);
        rd(0,  "R2 r0 shared", 32'h0100);
        wreg(13, 32'hC000_0013); wreg(8, 32'hC000_0008); wreg(14, 32'hC000_0014);

        // R3 fast interrupt
        setmode(32'hD1);
        rd(8,  "R3 fiq r8", 32'h0);
        rd(13, "R3 fiq r13", 32'h0);
        rd(0,  "R2 fiq r0", 32'h0100);
        wreg(8, 32'hF000_0008); wreg(14, 32'hF000_0014); wreg(15, 32'h0000_1500);
        setmode(32'h10);
        rd(8,  "R3 user r8 kept", 32'hC000_0008);
        rd(14, "R3 user r14 kept", 32'hC000_0014);
        rd(15, "R2 pc shared", 32'h0000_1500);
        setmode(32'h13);
        rd(13, "R4 svc r13", 32'hA000_0013);
        rd(15, "R2 svc pc", 32'h0000_1500);

        // R5 system
        setmode(32'h1F);
        rd(13, "R5 sys r13", 32'hC000_0013);
        spsr_we = 1; spsr_wdata = 32'hFFFF_FFFF; tick();
        chk("R5 sys spsr", spsr_q, 32'h0);
        chk("R5 sys cpsr", cpsr_q, 32'h1F);

        // R6 / R7 saved status
        setmode(32'h92);
        spsr_we = 1; spsr_wdata = 32'hFFFF_FFFF; tick();
        chk("R7 irq spsr masked", spsr_q, 32'hF000_00FF);
        rd(13, "R4 irq r13", 32'h0);
        setmode(32'h17);
        chk("R6 abt spsr", spsr_q, 32'h0);
        spsr_we = 1; spsr_wdata = 32'h3000_0055; tick();
        setmode(32'h12);
        chk("R6 irq spsr kept", spsr_q, 32'hF000_00FF);
        setmode(32'h0ABC_DE97);
        chk("R7 cpsr masked", cpsr_q, 32'h0000_0097);
        chk("R6 abt spsr", spsr_q, 32'h3000_0055);

        // R8 undefined code
        setmode(32'h15);
        rd(13, "R8 r13 as user", 32'hC000_0013);
        rd(8,  "R8 r8 as user", 32'hC000_0008);
        chk("R8 spsr", spsr_q, 32'h0);

        // R9 same-cycle read
        setmode(32'h10);
        wr_en = 1; wr_idx = 5; wr_data = 32'h55;
        rd(5, "R9 old value", 32'h0);
        tick();
        rd(5, "R9 new value", 32'h55);

        // R10 side port
        exc_we = 1; exc_mode = 5'h13; exc_lr = 32'hE000_0014; exc_spsr = 32'hFFFF_FFFF; tick();
        rd(14, "R10 user r14 untouched", 32'hC000_0014);
        setmode(32'h13);
        rd(14, "R10 svc lr", 32'hE000_0014);
        chk("R10 svc spsr", spsr_q, 32'hF000_00FF);
        wr_en = 1; wr_idx = 14; wr_data = 32'h1111;
        exc_we = 1; exc_mode = 5'h13; exc_lr = 32'h2222; exc_spsr = 32'h0; tick();
        rd(14, "R10 side wins", 32'h2222);
        chk("R10 spsr cleared", spsr_q, 32'h0);
        exc_we = 1; exc_mode = 5'h10; exc_lr = 32'h9999; exc_spsr = 32'h5; tick();
        rd(14, "R10 user target ignored svc", 32'h2222);
        chk("R10 user target spsr", spsr_q, 32'h0);
        setmode(32'h10);
        rd(14, "R10 user target ignored usr", 32'hC000_0014);

        // R11 write during mode change
        cpsr_we = 1; cpsr_wdata = 32'h11;
        wr_en = 1; wr_idx = 8; wr_data = 32'h0BEE; tick();
        rd(8, "R11 fiq r8 unchanged", 32'hF000_0008);
        setmode(32'h10);
        rd(8, "R11 user r8 written", 32'h0BEE);

        // random phase against the bench model (R9 comparisons every cycle)
        do_reset();
        for (int s = 0; s < 3000; s++) begin
            int cb;
            logic [4:0] md;
            rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
            wr_en = ($urandom % 2) == 0; wr_idx = 4'($urandom); wr_data = $urandom;
            cpsr_we = ($urandom % 4) == 0;
            cpsr_wdata = {$urandom} & 32'hFFFF_FFE0 | 32'(codes[$urandom % 8]);
            spsr_we = ($urandom % 4) == 0; spsr_wdata = $urandom;
            exc_we = ($urandom % 6) == 0; exc_mode = codes[$urandom % 8];
            exc_lr = $urandom; exc_spsr = $urandom;
            #1;
            md = m_cpsr[4:0];
            cb = t_bank(md);
            chk("R9 rand port A", rd_a_data, m_reg[t_map(md, rd_a_idx)]);
            chk("R9 rand port B", rd_b_data, m_reg[t_map(md, rd_b_idx)]);
            chk("R7 rand cpsr", cpsr_q, m_cpsr);
            chk("R6 rand spsr", spsr_q, cb == 0 ? 32'h0 : m_sav[cb]);
            @(posedge clk);
            if (wr_en) m_reg[t_map(md, wr_idx)] = wr_data;
            if (spsr_we && cb != 0) m_sav[cb] = spsr_wdata & KEEP;
            if (exc_we && t_bank(exc_mode) != 0) begin
                m_reg[t_map(exc_mode, 4'd14)] = exc_lr;
                m_sav[t_bank(exc_mode)] = exc_spsr & KEEP;
            end
            if (cpsr_we) m_cpsr = cpsr_wdata & KEEP;
            @(negedge clk);
            clr();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule